// File: doc/BRIEF.md
# Address Range Lookup Cache

This block is a three-slot, fully associative cache placed in front of a slow address-to-target decoder on a shared memory interconnect. Each slot remembers a target port id together with a half-open address window `[lo, hi)`. A lookup address is compared against every remembered window in the same cycle. The block then reports either a hit with the port id of the winning slot, or a miss with the id output driven to all ones.

When a lookup misses, the surrounding logic asks the slow decoder and writes the answer back through the update channel. The channel is a valid/ready stream. A write is accepted on a rising clock edge where `upd_valid` and `upd_ready` are both high. `upd_ready` is high in every cycle except those where `clr` is asserted. While `clr` is high, an offered update is not taken, and the producer keeps `upd_valid` and its fields steady until it sees `upd_ready` again.

An accepted update behaves like a short queue. Every slot moves one place toward the oldest position, the oldest slot's contents are lost, and the new window goes into slot 0. The `clr` pin and reset both empty the cache. Lookup is purely combinational and has no handshake.

Top module: `range_lookup_cache`

## Requirements
- R1: Between accepted updates and clears, the contents of all three slots are held, so a window inserted two updates earlier still hits.
- R2: A slot hits only when it is valid, `lkp_addr >= lo` and `lkp_addr < hi`. The lower bound is inclusive and the upper bound is exclusive, so a window with `lo >= hi` never hits.
- R3: When several slots hit, the lowest-numbered slot wins. Slot 0 always holds the most recently inserted window.
- R4: When no slot hits, `lkp_hit` is 0 and `lkp_id` is all ones. The all-ones id is reserved as the miss code.
- R5: An accepted update shifts slot 1 into slot 2 and slot 0 into slot 1, each with its valid flag. It then writes `{upd_id, upd_lo, upd_hi}` into slot 0 as valid, and the previous slot 2 is discarded.
- R6: Reset (`rst_n` low, asynchronous) and a `clr` edge each leave all three slots invalid, so every lookup misses afterwards.
- R7: `clr` takes priority over an update. While `clr` is high, `upd_ready` is 0, and an offered update leaves no trace after the edge.
- R8: No deduplication is done. Inserting a window equal to an existing one adds a new slot 0 entry, and a lookup in that window returns the newer id.
- R9: All bound comparisons are unsigned. An address with its top bit set compares as larger than any address with the top bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, empties the cache |
| clr | input | 1 | Synchronous invalidate of every slot |
| upd_valid | input | 1 | Update offered |
| upd_ready | output | 1 | Update can be accepted this cycle |
| upd_id | input | ID_W | Port id of the new window |
| upd_lo | input | ADDR_W | Inclusive lower bound of the new window |
| upd_hi | input | ADDR_W | Exclusive upper bound of the new window |
| lkp_addr | input | ADDR_W | Address to look up |
| lkp_hit | output | 1 | Some slot holds a window containing `lkp_addr` |
| lkp_id | output | ID_W | Id of the winning slot; all ones on a miss |

## Verification
The assertions assume the block sees reset before the first lookup. They also assume no update ever carries the all-ones id, since a hit would then look exactly like a miss. The stimulus respects both: it holds `rst_n` low for several cycles at the start, and it uses only ids 1 to 7. It drives the update fields and `clr` at the falling edge, so each offer is fully settled before the rising edge that may accept it.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  // Operation applied to the slot store on the next rising edge.
  typedef enum logic [1:0] {
    RLC_IDLE   = 2'd0,
    RLC_INSERT = 2'd1,
    RLC_CLEAR  = 2'd2
  } rlc_op_e;

  localparam int RLC_DEF_SLOTS  = 3;
  localparam int RLC_DEF_ADDR_W = 32;
  localparam int RLC_DEF_ID_W   = 4;

endpackage

// File: rtl/rlc_range_match.sv
module rlc_range_match #(
  parameter int ADDR_W = 32
) (
  input  logic              slot_valid,
  input  logic [ADDR_W-1:0] slot_lo,
  input  logic [ADDR_W-1:0] slot_hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic above_lo;
  logic below_hi;

  // Both operands are unsigned vectors, so the compares are unsigned.
  always_comb begin
    above_lo = (addr >= slot_lo);
    below_hi = (addr <  slot_hi);
    hit      = slot_valid && above_lo && below_hi;
  end

endmodule

// File: rtl/rlc_first_hit.sv
module rlc_first_hit #(
  parameter int SLOTS = 3,
  parameter int ID_W  = 4
) (
  input  logic [SLOTS-1:0]           match_vec,
  input  logic [SLOTS-1:0][ID_W-1:0] slot_id,
  output logic                       any_hit,
  output logic [ID_W-1:0]            win_id
);

  // Walk from the oldest slot toward slot 0 so the lowest index wins.
  always_comb begin
    any_hit = 1'b0;
    win_id  = '1;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (match_vec[k]) begin
        any_hit = 1'b1;
        win_id  = slot_id[k];
      end
    end
  end

endmodule

// File: rtl/rlc_slot_queue.sv
module rlc_slot_queue
  import rlc_pkg::*;
#(
  parameter int SLOTS  = 3,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  rlc_op_e                      op,
  input  logic [ID_W-1:0]              new_id,
  input  logic [ADDR_W-1:0]            new_lo,
  input  logic [ADDR_W-1:0]            new_hi,
  output logic [SLOTS-1:0]             valid_q,
  output logic [SLOTS-1:0][ID_W-1:0]   id_q,
  output logic [SLOTS-1:0][ADDR_W-1:0] lo_q,
  output logic [SLOTS-1:0][ADDR_W-1:0] hi_q
);

  // Slot 0 is loaded from the update fields, every other slot from its
  // younger neighbour; the oldest slot's old contents fall off the end.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              src_valid;
    logic [ID_W-1:0]   src_id;
    logic [ADDR_W-1:0] src_lo;
    logic [ADDR_W-1:0] src_hi;

    if (s == 0) begin : g_head
      assign src_valid = 1'b1;
      assign src_id    = new_id;
      assign src_lo    = new_lo;
      assign src_hi    = new_hi;
    end else begin : g_tail
      assign src_valid = valid_q[s-1];
      assign src_id    = id_q[s-1];
      assign src_lo    = lo_q[s-1];
      assign src_hi    = hi_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
      end else if (op == RLC_CLEAR) begin
        valid_q[s] <= 1'b0;
      end else if (op == RLC_INSERT) begin
        valid_q[s] <= src_valid;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q[s] <= '0;
        lo_q[s] <= '0;
        hi_q[s] <= '0;
      end else if (op == RLC_INSERT) begin
        id_q[s] <= src_id;
        lo_q[s] <= src_lo;
        hi_q[s] <= src_hi;
      end
    end

    if (s > 0) begin : g_shift_chk
      assert_shift_carries_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RLC_INSERT) |=> (valid_q[s] == $past(valid_q[s-1]))
                               && (lo_q[s] == $past(lo_q[s-1]))
                               && (id_q[s] == $past(id_q[s-1])));
    end
  end

  assert_insert_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RLC_INSERT) |=> valid_q[0] && (id_q[0] == $past(new_id))
                           && (lo_q[0] == $past(new_lo)) && (hi_q[0] == $past(new_hi)));

  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RLC_CLEAR) |=> (valid_q == '0));

  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RLC_IDLE) |=> $stable(valid_q) && $stable(lo_q) && $stable(hi_q) && $stable(id_q));

endmodule

// File: rtl/range_lookup_cache.sv
module range_lookup_cache
  import rlc_pkg::*;
#(
  parameter int ADDR_W = RLC_DEF_ADDR_W,
  parameter int ID_W   = RLC_DEF_ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ID_W-1:0]   upd_id,
  input  logic [ADDR_W-1:0] upd_lo,
  input  logic [ADDR_W-1:0] upd_hi,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_hit,
  output logic [ID_W-1:0]   lkp_id
);

  localparam int SLOTS = RLC_DEF_SLOTS;

  rlc_op_e                      op;
  logic [SLOTS-1:0]             slot_valid;
  logic [SLOTS-1:0][ID_W-1:0]   slot_id;
  logic [SLOTS-1:0][ADDR_W-1:0] slot_lo;
  logic [SLOTS-1:0][ADDR_W-1:0] slot_hi;
  logic [SLOTS-1:0]             match_vec;

  // Clear wins; an update is only taken when no clear is pending.
  assign upd_ready = !clr;

  always_comb begin
    if (clr)                         op = RLC_CLEAR;
    else if (upd_valid && upd_ready) op = RLC_INSERT;
    else                             op = RLC_IDLE;
  end

  rlc_slot_queue #(
    .SLOTS (SLOTS),
    .ADDR_W(ADDR_W),
    .ID_W  (ID_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .new_id (upd_id),
    .new_lo (upd_lo),
    .new_hi (upd_hi),
    .valid_q(slot_valid),
    .id_q   (slot_id),
    .lo_q   (slot_lo),
    .hi_q   (slot_hi)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    rlc_range_match #(
      .ADDR_W(ADDR_W)
    ) u_match (
      .slot_valid(slot_valid[s]),
      .slot_lo   (slot_lo[s]),
      .slot_hi   (slot_hi[s]),
      .addr      (lkp_addr),
      .hit       (match_vec[s])
    );
  end

  rlc_first_hit #(
    .SLOTS(SLOTS),
    .ID_W (ID_W)
  ) u_pick (
    .match_vec(match_vec),
    .slot_id  (slot_id),
    .any_hit  (lkp_hit),
    .win_id   (lkp_id)
  );

  assert_miss_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec == '0) |-> !lkp_hit && (lkp_id == '1));

  assert_slot0_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_vec[0] |-> lkp_hit && (lkp_id == slot_id[0]));

  assert_clear_blocks_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !upd_ready);

  assert_hit_needs_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> (slot_valid != '0));

endmodule

// File: tb/range_lookup_cache_tb.sv
`timescale 1ns/1ps
module range_lookup_cache_tb;

  localparam int AW = 32;
  localparam int IW = 4;

  typedef struct packed {
    logic [1:0]    op;     // 0 none, 1 insert, 2 clear
    logic [IW-1:0] id;
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
    logic [AW-1:0] addr;
    logic          ehit;
    logic [IW-1:0] eid;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd1, 32'h1000, 32'h2000, 32'h1000, 1'b1, 4'd1, 4'd2},      // R2 lower bound inclusive
    '{2'd0, 4'd0, 32'h0, 32'h0, 32'h1FFF, 1'b1, 4'd1, 4'd2},             // R2 last address inside
    '{2'd0, 4'd0, 32'h0, 32'h0, 32'h2000, 1'b0, 4'hF, 4'd4},             // R4 upper bound exclusive -> miss code
    '{2'd1, 4'd2, 32'h1800, 32'h3000, 32'h1800, 1'b1, 4'd2, 4'd3},      // R3 overlap, newest wins
    '{2'd0, 4'd0, 32'h0, 32'h0, 32'h1400, 1'b1, 4'd1, 4'd3},             // R3 older slot still used
    '{2'd1, 4'd3, 32'h4000, 32'h5000, 32'h4800, 1'b1, 4'd3, 4'd5},      // R5 third insert
    '{2'd0, 4'd0, 32'h0, 32'h0, 32'h1200, 1'b1, 4'd1, 4'd1},             // R1 oldest still held
    '{2'd1, 4'd4, 32'h6000, 32'h7000, 32'h1200, 1'b0, 4'hF, 4'd5},      // R5 oldest discarded
    '{2'd0, 4'd0, 32'h0, 32'h0, 32'h2800, 1'b1, 4'd2, 4'd5},             // R5 shifted to slot 2
    '{2'd0, 4'd0, 32'h0, 32'h0, 32'h6000, 1'b1, 4'd4, 4'd1},             // R1 newest held
    '{2'd2, 4'd0, 32'h0, 32'h0, 32'h6000, 1'b0, 4'hF, 4'd6},             // R6 clear empties
    '{2'd1, 4'd5, 32'h7FFF_FF00, 32'h8000_0100, 32'h8000_0000, 1'b1, 4'd5, 4'd9}, // R9 unsigned
    '{2'd0, 4'd0, 32'h0, 32'h0, 32'h7FFF_FEFF, 1'b0, 4'hF, 4'd9},        // R9 below window
    '{2'd1, 4'd6, 32'h7FFF_FF00, 32'h8000_0100, 32'h8000_0000, 1'b1, 4'd6, 4'd8}, // R8 duplicate kept
    '{2'd1, 4'd7, 32'h50, 32'h50, 32'h50, 1'b0, 4'hF, 4'd2}              // R2 empty window
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          upd_valid = 1'b0;
  logic          upd_ready;
  logic [IW-1:0] upd_id = '0;
  logic [AW-1:0] upd_lo = '0;
  logic [AW-1:0] upd_hi = '0;
  logic [AW-1:0] lkp_addr = '0;
  logic          lkp_hit;
  logic [IW-1:0] lkp_id;

  int  n_run = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  range_lookup_cache #(.ADDR_W(AW), .ID_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_id(upd_id), .upd_lo(upd_lo), .upd_hi(upd_hi),
    .lkp_addr(lkp_addr), .lkp_hit(lkp_hit), .lkp_id(lkp_id)
  );

  task automatic check(input int req, input logic ehit, input logic [IW-1:0] eid);
    n_run++;
    if (lkp_hit !== ehit || lkp_id !== eid) begin
      n_fail++;
      $display("FAIL R%0d: hit=%0b id=%0h expected hit=%0b id=%0h", req, lkp_hit, lkp_id, ehit, eid);
    end
  endtask

  task automatic insert(input logic [IW-1:0] id, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    @(negedge clk);
    upd_valid = 1'b1; upd_id = id; upd_lo = lo; upd_hi = hi;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cyc);
      finish_run();
    end
  end

  initial begin
    // R6 reset state
    repeat (3) @(negedge clk);
    lkp_addr = 32'h0;
    #0.5 check(6, 1'b0, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    #0.5 check(6, 1'b0, 4'hF);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      upd_valid = (VECS[v].op == 2'd1);
      clr       = (VECS[v].op == 2'd2);
      upd_id    = VECS[v].id;
      upd_lo    = VECS[v].lo;
      upd_hi    = VECS[v].hi;
      lkp_addr  = VECS[v].addr;
      @(negedge clk);
      upd_valid = 1'b0;
      clr       = 1'b0;
      #0.5 check(int'(VECS[v].req), VECS[v].ehit, VECS[v].eid);
    end

    // R7 clear beats a simultaneous update
    @(negedge clk); clr = 1'b1;
    insert(4'd1, 32'h0, 32'h100);
    // the insert above was offered while clr was high
    @(negedge clk);
    clr = 1'b0;
    lkp_addr = 32'h50;
    #0.5 check(7, 1'b0, 4'hF);
    @(negedge clk);
    clr = 1'b1; upd_valid = 1'b1; upd_id = 4'd2; upd_lo = 32'h200; upd_hi = 32'h300;
    #0.5 n_run++;
    if (upd_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R7: upd_ready=%0b expected 0", upd_ready);
    end
    @(negedge clk);
    clr = 1'b0; upd_valid = 1'b0;
    lkp_addr = 32'h250;
    #0.5 check(7, 1'b0, 4'hF);

    // R8 same window twice, newest id answers, older copy behind it
    insert(4'd3, 32'hA000, 32'hB000);
    insert(4'd4, 32'hA000, 32'hB000);
    lkp_addr = 32'hA010;
    #0.5 check(8, 1'b1, 4'd4);

    // R6 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #0.5 check(6, 1'b0, 4'hF);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5 check(6, 1'b0, 4'hF);

    finish_run();
  end

endmodule